// File: doc/BRIEF.md
# Bipolar Stepper Phase Sequencer

This block turns a step clock into switch enables for two full H-bridges that drive the coils of a two-phase bipolar stepper motor. Each motor terminal (T1, T2 on coil one; T3, T4 on coil two) gets a high-side enable and a low-side enable. The rotor position is kept as a three-bit half-step index. Each rising edge of the step input moves the index one position. In full-step mode that is a move of two, and in half-step mode a move of one. A direction input sets which way the index moves.

In half-step mode, the odd positions energize one coil only. For the idle coil, an impedance input chooses between two states: both terminals floating, or both terminals clamped to the high side. An asynchronous park input floats the whole bridge at once and pulls the position back to home (position A). The active-low home indicator is asserted while the block is parked or at home. The step, direction, mode and impedance inputs are first passed through a synchronizer, and the step input then goes through an edge detector.

The position register is an enumerated state machine with eight states, POS_A to POS_H. There are four named transitions:
- HALF_FWD: index plus one.
- HALF_REV: index minus one.
- FULL_FWD: index plus two from an even state, or plus one from an odd state.
- FULL_REV: index minus two from an even state, or minus one from an odd state.

A fifth transition, PARK_HOME, forces POS_A whenever park is seen. With no step edge, a state holds.

Top module: `stepper_seq`

## Requirements
- R1: While rst_n is low, and while park is high, all eight enables are 0 and home_n is 0. After park is released, the position is A.
- R2: The position advances exactly once for each rising edge of step_in. Holding step_in high, or its falling edge, changes nothing.
- R3: With half_mode=0 and ccw=0, steps visit A,C,E,G (index 0,2,4,6) cyclically, and both coils are driven at every position. The bridge patterns are:
  - index 0: T1 high, T2 low, T3 high, T4 low.
  - index 2: T1 low, T2 high, T3 high, T4 low.
  - index 4: T1 low, T2 high, T3 low, T4 high.
  - index 6: T1 high, T2 low, T3 low, T4 high.
- R4: With half_mode=1 and ccw=0, steps visit index 0..7 cyclically. Even indices use the R3 patterns. The odd indices are:
  - index 1: coil one idle, T3 high, T4 low.
  - index 3: T1 low, T2 high, coil two idle.
  - index 5: coil one idle, T3 low, T4 high.
  - index 7: T1 high, T2 low, coil two idle.
- R5: ccw=1 reverses the order in both modes, so A then G then E then C in full-step mode and A then H then G in half-step mode.
- R6: With hold_hi=0, both terminals of an idle coil have both enables at 0.
- R7: With hold_hi=1, both terminals of an idle coil have the high-side enable at 1 and the low-side enable at 0.
- R8: When not parked, home_n is 0 exactly when the position is A (index 0).
- R9: While park is high, step edges and the mode, direction and impedance inputs are ignored. After release, the outputs show position A and the next step edge moves on from A.
- R10: A full step taken from an odd index moves to the adjacent even index in the selected direction.
- R11: The high-side and low-side enables of one terminal are never both 1.
- Port bit order: bit 0 is T1, bit 1 is T2, bit 2 is T3, bit 3 is T4. A high-side enable of 1 drives the terminal high, and a low-side enable of 1 drives it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Asynchronous step clock; each rising edge advances the position |
| ccw | input | 1 | Direction: 0 forward, 1 reverse |
| half_mode | input | 1 | 0 full-step, 1 half-step |
| hold_hi | input | 1 | Idle-coil state: 0 floating, 1 high-side clamp |
| park | input | 1 | Asynchronous park: float the bridge and return home |
| hi_en | output | 4 | High-side enables, bit 0 = T1 to bit 3 = T4 |
| lo_en | output | 4 | Low-side enables, bit 0 = T1 to bit 3 = T4 |
| home_n | output | 1 | Active-low home (position A) indicator |

## Verification
The bench builds the block with SYNC_STAGES=3 instead of the default of 2. This shows that the latency from step edge to output is set by the parameter alone, and that step pulses longer than that latency advance exactly once. With three stages, the park window is also long enough to check that a raw park floats the bridge at once, even though the position clear arrives several cycles later. It also checks that step edges inside that synchronizer window are lost, not queued.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

    typedef enum logic [2:0] {
        POS_A = 3'd0,
        POS_B = 3'd1,
        POS_C = 3'd2,
        POS_D = 3'd3,
        POS_E = 3'd4,
        POS_F = 3'd5,
        POS_G = 3'd6,
        POS_H = 3'd7
    } pos_e;

    typedef enum logic [1:0] {
        COIL_IDLE = 2'd0,
        COIL_FWD  = 2'd1,
        COIL_BACK = 2'd2
    } coil_e;

    localparam int unsigned NUM_COILS = 2;
    localparam int unsigned NUM_TERMS = 2 * NUM_COILS;

endpackage

// File: rtl/stepper_sync.sv
module stepper_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/stepper_edge.sv
module stepper_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign rise = level & ~level_d;
endmodule

// File: rtl/stepper_fsm.sv
module stepper_fsm
    import stepper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_rise,
    input  logic ccw,
    input  logic half_mode,
    input  logic park_s,
    output pos_e pos
);
    pos_e pos_q, pos_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= POS_A;
        else        pos_q <= pos_nxt;
    end

    always_comb begin
        pos_nxt = pos_q;
        if (park_s) begin
            pos_nxt = POS_A;                                   // PARK_HOME
        end else if (step_rise) begin
            unique case ({half_mode, ccw})
                2'b10: pos_nxt = pos_e'(pos_q + 3'd1);         // HALF_FWD
                2'b11: pos_nxt = pos_e'(pos_q - 3'd1);         // HALF_REV
                2'b00: pos_nxt = pos_q[0] ? pos_e'(pos_q + 3'd1)
                                          : pos_e'(pos_q + 3'd2); // FULL_FWD
                2'b01: pos_nxt = pos_q[0] ? pos_e'(pos_q - 3'd1)
                                          : pos_e'(pos_q - 3'd2); // FULL_REV
                default: pos_nxt = pos_q;
            endcase
        end
    end

    assign pos = pos_q;

    assert_park_home_R1: assert property (@(posedge clk) disable iff (!rst_n)
        park_s |=> (pos_q == POS_A));

    assert_hold_without_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_rise && !park_s) |=> $stable(pos_q));

    assert_half_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && half_mode && !park_s) |=>
            ((3'(pos_q - $past(pos_q)) == 3'd1) || (3'(pos_q - $past(pos_q)) == 3'd7)));

    assert_full_lands_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && !half_mode && !park_s) |=> (pos_q[0] == 1'b0));
endmodule

// File: rtl/stepper_bridge.sv
module stepper_bridge
    import stepper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  pos_e                 pos,
    input  logic                 hold_hi,
    input  logic                 park,
    output logic [NUM_TERMS-1:0] hi_en,
    output logic [NUM_TERMS-1:0] lo_en,
    output logic                 home_n
);
    coil_e coil [NUM_COILS];
    logic [NUM_TERMS-1:0] hi_raw, lo_raw;

    always_comb begin
        unique case (pos)
            POS_A: begin coil[0] = COIL_FWD;  coil[1] = COIL_FWD;  end
            POS_B: begin coil[0] = COIL_IDLE; coil[1] = COIL_FWD;  end
            POS_C: begin coil[0] = COIL_BACK; coil[1] = COIL_FWD;  end
            POS_D: begin coil[0] = COIL_BACK; coil[1] = COIL_IDLE; end
            POS_E: begin coil[0] = COIL_BACK; coil[1] = COIL_BACK; end
            POS_F: begin coil[0] = COIL_IDLE; coil[1] = COIL_BACK; end
            POS_G: begin coil[0] = COIL_FWD;  coil[1] = COIL_BACK; end
            POS_H: begin coil[0] = COIL_FWD;  coil[1] = COIL_IDLE; end
            default: begin coil[0] = COIL_IDLE; coil[1] = COIL_IDLE; end
        endcase
    end

    for (genvar c = 0; c < NUM_COILS; c++) begin : g_coil
        always_comb begin
            unique case (coil[c])
                COIL_FWD: begin
                    hi_raw[2*c +: 2] = 2'b01;
                    lo_raw[2*c +: 2] = 2'b10;
                end
                COIL_BACK: begin
                    hi_raw[2*c +: 2] = 2'b10;
                    lo_raw[2*c +: 2] = 2'b01;
                end
                default: begin
                    hi_raw[2*c +: 2] = hold_hi ? 2'b11 : 2'b00;
                    lo_raw[2*c +: 2] = 2'b00;
                end
            endcase
        end
    end

    always_comb begin
        hi_en  = park ? '0 : hi_raw;
        lo_en  = park ? '0 : lo_raw;
        home_n = ~(park || (pos == POS_A));
    end

    assert_no_shoot_through_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en & lo_en) == '0);

    assert_park_floats_R1: assert property (@(posedge clk) disable iff (!rst_n)
        park |-> (hi_en == '0 && lo_en == '0 && !home_n));

    assert_home_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!park && !home_n) |-> (hi_en == 4'b0101 && lo_en == 4'b1010));
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
    import stepper_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_in,
    input  logic       ccw,
    input  logic       half_mode,
    input  logic       hold_hi,
    input  logic       park,
    output logic [3:0] hi_en,
    output logic [3:0] lo_en,
    output logic       home_n
);
    localparam int unsigned SYNC_W = 5;

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic step_s, ccw_s, half_s, hold_s, park_s, step_rise;
    pos_e pos;

    assign raw_in = {park, hold_hi, half_mode, ccw, step_in};
    assign {park_s, hold_s, half_s, ccw_s, step_s} = sync_out;

    stepper_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
    );

    stepper_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level(step_s & ~park_s), .rise(step_rise)
    );

    stepper_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .step_rise(step_rise), .ccw(ccw_s),
        .half_mode(half_s), .park_s(park_s), .pos(pos)
    );

    stepper_bridge u_bridge (
        .clk(clk), .rst_n(rst_n), .pos(pos), .hold_hi(hold_s),
        .park(park | ~rst_n), .hi_en(hi_en), .lo_en(lo_en), .home_n(home_n)
    );
endmodule

// File: tb/tb_stepper_seq.sv
`timescale 1ns/1ps
module tb_stepper_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_in = 1'b0, ccw = 1'b0, half_mode = 1'b0, hold_hi = 1'b0, park = 1'b0;
    logic [3:0] hi_en, lo_en;
    logic home_n;

    int checks = 0;
    int errors = 0;
    int model_idx = 0;
    int overlap_seen = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    stepper_seq #(.SYNC_STAGES(3)) dut (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .ccw(ccw),
        .half_mode(half_mode), .hold_hi(hold_hi), .park(park),
        .hi_en(hi_en), .lo_en(lo_en), .home_n(home_n)
    );

    // R11 monitor: every cycle, away from the edge
    always @(negedge clk) if ((hi_en & lo_en) != 4'b0) overlap_seen++;

    // Coil polarity per index: 1 forward, -1 reverse, 0 idle (R3, R4)
    function automatic void expect_pattern(input int idx, input logic hh,
                                           output logic [3:0] eh, output logic [3:0] el);
        int p [2];
        case (idx)
            0: begin p[0] =  1; p[1] =  1; end
            1: begin p[0] =  0; p[1] =  1; end
            2: begin p[0] = -1; p[1] =  1; end
            3: begin p[0] = -1; p[1] =  0; end
            4: begin p[0] = -1; p[1] = -1; end
            5: begin p[0] =  0; p[1] = -1; end
            6: begin p[0] =  1; p[1] = -1; end
            default: begin p[0] = 1; p[1] = 0; end
        endcase
        eh = 4'b0; el = 4'b0;
        for (int c = 0; c < 2; c++) begin
            if (p[c] == 1)       begin eh[2*c] = 1'b1;   el[2*c+1] = 1'b1; end
            else if (p[c] == -1) begin eh[2*c+1] = 1'b1; el[2*c] = 1'b1;   end
            else if (hh)         begin eh[2*c] = 1'b1;   eh[2*c+1] = 1'b1; end
        end
    endfunction

    function automatic int next_idx(input int idx, input logic hm, input logic rev);
        int d;
        d = (hm || (idx % 2 == 1)) ? 1 : 2;
        return rev ? (idx - d + 8) % 8 : (idx + d) % 8;
    endfunction

    task automatic check(input string req, input logic [3:0] eh, input logic [3:0] el,
                         input logic eph);
        checks++;
        if (hi_en !== eh || lo_en !== el || home_n !== eph) begin
            errors++;
            $display("FAIL %s: hi=%b lo=%b home_n=%b expected hi=%b lo=%b home_n=%b",
                     req, hi_en, lo_en, home_n, eh, el, eph);
        end
    endtask

    task automatic check_model(input string req);
        logic [3:0] eh, el;
        expect_pattern(model_idx, hold_hi, eh, el);
        check(req, eh, el, (model_idx != 0));
    endtask

    task automatic pulse(input bit update_model);
        @(negedge clk) step_in = 1'b1;
        repeat (8) @(negedge clk);
        step_in = 1'b0;
        repeat (8) @(negedge clk);
        if (update_model) model_idx = next_idx(model_idx, half_mode, ccw);
    endtask

    task automatic set_mode(input logic hm, input logic rev, input logic hh);
        @(negedge clk);
        half_mode = hm; ccw = rev; hold_hi = hh;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_park();
        @(negedge clk) park = 1'b1;
        repeat (8) @(negedge clk);
        park = 1'b0;
        repeat (8) @(negedge clk);
        model_idx = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 in reset", 4'b0, 4'b0, 1'b0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check_model("R8 home after reset");
    endtask

    task automatic t_full_fwd();
        set_mode(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            pulse(1);
            check_model("R3 full forward");
        end
    endtask

    task automatic t_full_rev();
        set_mode(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) begin
            pulse(1);
            check_model("R5 full reverse");
        end
    endtask

    task automatic t_half_fwd_float();
        set_mode(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 9; i++) begin
            pulse(1);
            check_model((model_idx % 2) ? "R6 idle coil floats" : "R4 half forward");
        end
    endtask

    task automatic t_half_rev_clamp();
        set_mode(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 9; i++) begin
            pulse(1);
            check_model((model_idx % 2) ? "R7 idle coil clamped" : "R5 half reverse");
        end
    endtask

    task automatic t_edge_only();
        set_mode(1'b1, 1'b0, 1'b0);
        @(negedge clk) step_in = 1'b1;
        repeat (30) @(negedge clk);
        model_idx = next_idx(model_idx, 1'b1, 1'b0);
        check_model("R2 held high advances once");
        step_in = 1'b0;
        repeat (12) @(negedge clk);
        check_model("R2 falling edge no change");
    endtask

    task automatic t_odd_to_full();
        set_mode(1'b1, 1'b0, 1'b0);
        if (model_idx % 2 == 0) pulse(1);
        set_mode(1'b0, 1'b0, 1'b0);
        pulse(1);
        check_model("R10 odd to even forward");
        set_mode(1'b1, 1'b0, 1'b0);
        pulse(1);
        set_mode(1'b0, 1'b1, 1'b0);
        pulse(1);
        check_model("R10 odd to even reverse");
    endtask

    task automatic t_park();
        set_mode(1'b1, 1'b0, 1'b1);
        pulse(1);
        pulse(1);
        @(negedge clk) park = 1'b1;
        @(negedge clk);
        check("R1 park floats at once", 4'b0, 4'b0, 1'b0);
        repeat (6) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            step_in = 1'b1; half_mode = ~half_mode; ccw = ~ccw; hold_hi = ~hold_hi;
            repeat (6) @(negedge clk);
            step_in = 1'b0;
            repeat (6) @(negedge clk);
            check("R9 inputs ignored while parked", 4'b0, 4'b0, 1'b0);
        end
        park = 1'b0;
        half_mode = 1'b0; ccw = 1'b0; hold_hi = 1'b0;
        repeat (10) @(negedge clk);
        model_idx = 0;
        check_model("R9 resumes at home");
        pulse(1);
        check_model("R9 steps from home");
        check_model("R8 home flag clear");
        do_park();
        check_model("R1 home after park");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_full_fwd();
        t_full_rev();
        t_half_fwd_float();
        t_half_rev_clamp();
        t_edge_only();
        t_odd_to_full();
        t_park();
        checks++;
        if (overlap_seen != 0) begin
            errors++;
            $display("FAIL R11: %0d cycles with both enables on, expected 0", overlap_seen);
        end
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule